// File: doc/BRIEF.md
# Serial Byte Memory Slave

This block is the target side of a byte-wide memory reached over a four-wire serial link in clock mode 0. A host lowers the select line, shifts in an 8-bit command, optionally two address bytes, and then moves any number of data bytes. An internal address counter steps after every byte, so one transaction can stream through the whole address space. A small status byte carries three configuration bits that persist between transactions, plus a write-enable flag that gates every write.

The host can pause a transfer with the active-low pause input. While paused, the block ignores serial clock and select activity and releases its output. When the pause ends, the transfer resumes at the bit where it stopped. An active-low lock input protects the status configuration bits and leaves the memory array writable.

All pins are sampled in the system clock domain. Serial clock edges are detected by comparing each sample with the one before, so the system clock must run at least four times faster than the serial clock. Input bits are captured on serial clock rises; output bits change on serial clock falls. The storage array holds 2^MEM_AW bytes and is indexed by the low MEM_AW bits of the ADDR_W-bit address.

Top module: `spi_mem`

## Requirements
- R1: After reset, sdoEn is 0 and a status read (command 0x05) returns 0x00.
- R2: Command 0x06 sets the write-enable flag and command 0x04 clears it. The status byte shows the flag in bit 1 and the configuration bits in bits 7, 3 and 2; all other bits read 0.
- R3: A memory write (command 0x02) issued while the write-enable flag is clear leaves the array unchanged.
- R4: A memory write (0x02) or read (0x03) takes two address bytes, high byte first, and the top address bit is ignored. A byte written at an address reads back from that address.
- R5: During a burst, the address advances by one after each data byte and wraps from 0x7FFF to 0x0000.
- R6: When select rises after a status write or memory write command was received, the write-enable flag clears.
- R7: A status write (command 0x01) with the flag set and the lock input high loads bits 7, 3 and 2 from the data byte. With the lock input low, the status bits do not change, while memory writes still succeed.
- R8: An unrecognised command causes the rest of the transaction to be ignored until select rises, and the output stays released.
- R9: While the pause input is low, the output is released and serial clock and select transitions have no effect. After release, the transfer continues at the same bit.
- R10: sdoEn is 1 only during the data phase of a read with select low. It is 0 during writes and while select is high.
- R11: The array stores each byte at the low MEM_AW bits of the address, so addresses equal modulo 2^MEM_AW alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; high puts the block in standby |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, captured on sclk rises |
| sdo | output | 1 | Serial data out, changes on sclk falls |
| sdoEn | output | 1 | Output drive enable; 0 means the pin is released |
| holdN | input | 1 | Active-low pause of the current transfer |
| wpN | input | 1 | Active-low lock of the status configuration bits |

## Verification
The bench builds the block with ADDR_W = 15 and MEM_AW = 6, which gives a 64-byte array behind the full 15-bit address. With this setting, both ends of the address range land on real storage words, so the 0x7FFF to 0x0000 wrap during a burst can be read back. Addresses that differ above bit 5 alias onto the same byte, which lets the bench observe the low-bit indexing and the ignored top address bit with a handful of writes.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RDSR,
    OP_WRSR,
    OP_READ,
    OP_WRITE
  } op_e;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WRSR  = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WRITE = 8'h02;

  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic memWrite;
    logic statWrite;
    logic setWel;
    logic clrWel;
    logic txLoadMem;
    logic txLoadStat;
    logic txShift;
  } strobe_t;

endpackage

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       holdN,
  input  logic [7:0] rxByte,
  output strobe_t    stb,
  output logic       drive
);

  logic       sclkQ;
  logic       selQ;
  logic [2:0] bitCnt;
  phase_e     phase;
  op_e        op;
  logic       wrOp;
  logic       driveQ;

  logic csFall, csRise, sclkRise, sclkFall, byteDone, isRead;

  always_comb begin
    csFall   = holdN & ~csN & ~selQ;
    csRise   = holdN & csN & selQ;
    sclkRise = holdN & ~csN & selQ & sclk & ~sclkQ;
    sclkFall = holdN & ~csN & selQ & ~sclk & sclkQ;
    byteDone = sclkRise & (bitCnt == 3'd7);
    isRead   = (phase == PH_DATA) & ((op == OP_READ) | (op == OP_RDSR));
  end

  always_comb begin
    stb = '0;
    stb.shiftIn = sclkRise;
    if (byteDone) begin
      unique case (phase)
        PH_OPC: begin
          if (rxByte == CMD_WREN) stb.setWel = 1'b1;
          if (rxByte == CMD_WRDI) stb.clrWel = 1'b1;
        end
        PH_AHI:  stb.loadHi = 1'b1;
        PH_ALO:  stb.loadLo = 1'b1;
        PH_DATA: begin
          stb.memWrite  = (op == OP_WRITE);
          stb.statWrite = (op == OP_WRSR);
        end
        default: ;
      endcase
    end
    if (csRise & wrOp) stb.clrWel = 1'b1;
    if (sclkFall & isRead) begin
      if (bitCnt == 3'd0) begin
        stb.txLoadMem  = (op == OP_READ);
        stb.txLoadStat = (op == OP_RDSR);
      end else begin
        stb.txShift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      selQ   <= 1'b0;
      bitCnt <= '0;
      phase  <= PH_IDLE;
      op     <= OP_NONE;
      wrOp   <= 1'b0;
      driveQ <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (holdN) selQ <= ~csN;
      if (csFall) begin
        phase  <= PH_OPC;
        bitCnt <= '0;
        op     <= OP_NONE;
        wrOp   <= 1'b0;
        driveQ <= 1'b0;
      end else if (csRise) begin
        phase  <= PH_IDLE;
        wrOp   <= 1'b0;
        driveQ <= 1'b0;
      end else begin
        if (sclkRise) bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          unique case (phase)
            PH_OPC: begin
              unique case (rxByte)
                CMD_READ:  begin op <= OP_READ;  phase <= PH_AHI; end
                CMD_WRITE: begin op <= OP_WRITE; wrOp <= 1'b1; phase <= PH_AHI; end
                CMD_RDSR:  begin op <= OP_RDSR;  phase <= PH_DATA; end
                CMD_WRSR:  begin op <= OP_WRSR;  wrOp <= 1'b1; phase <= PH_DATA; end
                default:   phase <= PH_SKIP;
              endcase
            end
            PH_AHI:  phase <= PH_ALO;
            PH_ALO:  phase <= PH_DATA;
            PH_DATA: if (op == OP_WRSR) phase <= PH_SKIP;
            default: ;
          endcase
        end
        if (sclkFall & isRead & (bitCnt == 3'd0)) driveQ <= 1'b1;
      end
    end
  end

  assign drive = driveQ & holdN & ~csN;

endmodule

// File: rtl/spi_mem_dpath.sv
module spi_mem_dpath
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  logic              wpN,
  input  strobe_t           stb,
  output logic [7:0]        rxByte,
  output logic              sdo,
  output logic [ADDR_W-1:0] addrCur,
  output logic              welBit,
  output logic [7:0]        statByte
);

  localparam int DEPTH = 1 << MEM_AW;
  localparam int HI_W  = ADDR_W - 8;

  logic [6:0]        rxShift;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        txQ;
  logic              welQ;
  logic [2:0]        cfgQ;
  logic [7:0]        mem [DEPTH];
  logic [MEM_AW-1:0] memIdx;

  assign rxByte   = {rxShift, sdi};
  assign memIdx   = addrQ[MEM_AW-1:0];
  assign statByte = {cfgQ[2], 3'b000, cfgQ[1], cfgQ[0], welQ, 1'b0};

  always_ff @(posedge clk) begin
    if (stb.memWrite & welQ) mem[memIdx] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      addrQ   <= '0;
      txQ     <= '0;
      welQ    <= 1'b0;
      cfgQ    <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= rxByte[6:0];
      if (stb.loadHi) addrQ[ADDR_W-1:8] <= rxByte[HI_W-1:0];
      if (stb.loadLo) addrQ[7:0] <= rxByte;
      if (stb.memWrite | stb.txLoadMem) addrQ <= addrQ + ADDR_W'(1);
      if (stb.txLoadMem)       txQ <= mem[memIdx];
      else if (stb.txLoadStat) txQ <= statByte;
      else if (stb.txShift)    txQ <= {txQ[6:0], 1'b0};
      if (stb.setWel)      welQ <= 1'b1;
      else if (stb.clrWel) welQ <= 1'b0;
      if (stb.statWrite & welQ & wpN) cfgQ <= {rxByte[7], rxByte[3], rxByte[2]};
    end
  end

  assign sdo     = txQ[7];
  assign addrCur = addrQ;
  assign welBit  = welQ;

endmodule

// File: rtl/spi_mem.sv
module spi_mem
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdoEn,
  input  logic holdN,
  input  logic wpN
);

  strobe_t           stb;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] addrCur;
  logic              welBit;
  logic [7:0]        statByte;

  spi_mem_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .holdN  (holdN),
    .rxByte (rxByte),
    .stb    (stb),
    .drive  (sdoEn)
  );

  spi_mem_dpath #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .sdi      (sdi),
    .wpN      (wpN),
    .stb      (stb),
    .rxByte   (rxByte),
    .sdo      (sdo),
    .addrCur  (addrCur),
    .welBit   (welBit),
    .statByte (statByte)
  );

endmodule

// File: rtl/spi_mem_checker.sv
module spi_mem_checker
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              holdN,
  input logic              wpN,
  input strobe_t           stb,
  input logic [ADDR_W-1:0] addrCur,
  input logic              welBit,
  input logic [7:0]        statByte
);

  // R9: a paused transfer issues no action strobes
  a_r9_hold_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !holdN |-> (stb == '0));

  // R9: the address counter is frozen while paused
  a_r9_hold_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !holdN |=> $stable(addrCur));

  // R7: lock input low keeps the configuration bits
  a_r7_lock_keeps_cfg: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> $stable({statByte[7], statByte[3:2]}));

  // R5: every data byte moved steps the address by one
  a_r5_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memWrite || stb.txLoadMem) |=> (addrCur == $past(addrCur) + ADDR_W'(1)));

  // R2: the flag only rises after a set request
  a_r2_wel_rise_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(welBit) |-> $past(stb.setWel));

  // R2: set and clear requests never coincide
  a_r2_wel_req_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setWel, stb.clrWel}));

endmodule

bind spi_mem spi_mem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .holdN    (holdN),
  .wpN      (wpN),
  .stb      (stb),
  .addrCur  (addrCur),
  .welBit   (welBit),
  .statByte (statByte)
);

// File: tb/spi_mem_bench.sv
module spi_mem_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic holdN = 1'b1;
  logic wpN = 1'b1;
  logic sdo, sdoEn;

  int nRun = 0;
  int nFail = 0;
  logic enSeen;
  logic doneFlag = 1'b0;

  always #5 clk = ~clk;

  spi_mem #(.ADDR_W(15), .MEM_AW(6)) u_spi_mem (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoEn(sdoEn), .holdN(holdN), .wpN(wpN)
  );

  // address, data
  localparam logic [23:0] VEC [6] = '{
    {16'h0000, 8'hA5}, {16'h0013, 8'h3C}, {16'h002A, 8'h81},
    {16'h003F, 8'hFE}, {16'h1234, 8'h5D}, {16'h7FFE, 8'h07}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doHold();
    holdN = 1'b0;
    tick(2);
    check("R9 output released during pause", {7'd0, sdoEn}, 8'd0);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; sdi = ~sdi; tick(2);
      sclk = 1'b0; tick(2);
    end
    csN = 1'b1; tick(2);
    csN = 1'b0; tick(2);
    holdN = 1'b1;
    tick(2);
  endtask

  task automatic xfer(input logic [7:0] tx, input int holdAt, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      if (i == holdAt) doHold();
      sdi = tx[i];
      tick(2);
      rx[i] = sdo;
      enSeen = sdoEn;
      sclk = 1'b1; tick(2);
      sclk = 1'b0; tick(2);
    end
  endtask

  task automatic csStart();
    csN = 1'b0; tick(2);
  endtask

  task automatic csEnd();
    tick(2); csN = 1'b1; tick(4);
  endtask

  task automatic cmd1(input logic [7:0] c);
    logic [7:0] r;
    csStart(); xfer(c, -1, r); csEnd();
  endtask

  task automatic rdStat(output logic [7:0] s);
    logic [7:0] r;
    csStart(); xfer(8'h05, -1, r); xfer(8'h00, -1, s); csEnd();
  endtask

  task automatic wrByte(input logic [15:0] a, input logic [7:0] d, input bit wren);
    logic [7:0] r;
    if (wren) cmd1(8'h06);
    csStart();
    xfer(8'h02, -1, r); xfer(a[15:8], -1, r); xfer(a[7:0], -1, r); xfer(d, -1, r);
    csEnd();
  endtask

  task automatic rdByte(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] r;
    csStart();
    xfer(8'h03, -1, r); xfer(a[15:8], -1, r); xfer(a[7:0], -1, r); xfer(8'h00, -1, d);
    csEnd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s, r;
    tick(3);
    rstN = 1'b1;
    tick(3);

    // R1 reset state
    check("R1 sdoEn after reset", {7'd0, sdoEn}, 8'd0);
    rdStat(s);
    check("R1 status after reset", s, 8'h00);

    // R2 write-enable flag set and clear
    cmd1(8'h06); rdStat(s);
    check("R2 flag set by 0x06", s, 8'h02);
    cmd1(8'h04); rdStat(s);
    check("R2 flag cleared by 0x04", s, 8'h00);

    // R4 table of single writes and reads
    for (int i = 0; i < 6; i++) wrByte(VEC[i][23:8], VEC[i][7:0], 1'b1);
    for (int i = 0; i < 6; i++) begin
      rdByte(VEC[i][23:8], v);
      check("R4 table readback", v, VEC[i][7:0]);
    end

    // R4 top address bit ignored, R11 aliasing
    wrByte(16'h8005, 8'h96, 1'b1);
    rdByte(16'h0005, v);
    check("R4 top address bit ignored", v, 8'h96);
    rdByte(16'h0045, v);
    check("R11 low-bit aliasing", v, 8'h96);

    // R3 write without flag
    wrByte(16'h0010, 8'h11, 1'b1);
    wrByte(16'h0010, 8'hEE, 1'b0);
    rdByte(16'h0010, v);
    check("R3 write without flag ignored", v, 8'h11);

    // R6 flag cleared after write
    wrByte(16'h0011, 8'h22, 1'b1);
    rdStat(s);
    check("R6 flag clear after memory write", s, 8'h00);

    // R5 burst with wrap
    cmd1(8'h06);
    csStart();
    xfer(8'h02, -1, r); xfer(8'h7F, -1, r); xfer(8'hFF, -1, r);
    xfer(8'h11, -1, r); xfer(8'h22, -1, r); xfer(8'h33, -1, r);
    check("R10 no drive during write", {7'd0, enSeen}, 8'd0);
    csEnd();
    csStart();
    xfer(8'h03, -1, r); xfer(8'h7F, -1, r); xfer(8'hFF, -1, r);
    xfer(8'h00, -1, v); check("R5 burst byte at 7FFF", v, 8'h11);
    xfer(8'h00, -1, v); check("R5 burst wrapped to 0000", v, 8'h22);
    xfer(8'h00, -1, v); check("R5 burst at 0001", v, 8'h33);
    check("R10 drive during read data", {7'd0, enSeen}, 8'd1);
    csEnd();
    check("R10 released after select high", {7'd0, sdoEn}, 8'd0);

    // R8 unknown command
    csStart();
    xfer(8'h55, -1, r); xfer(8'h06, -1, r);
    check("R8 no drive after unknown command", {7'd0, enSeen}, 8'd0);
    csEnd();
    rdStat(s);
    check("R8 later byte ignored", s, 8'h00);

    // R9 pause during read and write
    wrByte(16'h0030, 8'hC3, 1'b1);
    csStart();
    xfer(8'h03, -1, r); xfer(8'h00, -1, r); xfer(8'h30, -1, r);
    xfer(8'h00, 4, v);
    csEnd();
    check("R9 read resumes after pause", v, 8'hC3);
    cmd1(8'h06);
    csStart();
    xfer(8'h02, -1, r); xfer(8'h00, -1, r); xfer(8'h31, 3, r);
    xfer(8'h3C, 5, r);
    csEnd();
    rdByte(16'h0031, v);
    check("R9 write resumes after pause", v, 8'h3C);

    // R7 status write and lock input
    cmd1(8'h06);
    csStart(); xfer(8'h01, -1, r); xfer(8'hFF, -1, r); csEnd();
    rdStat(s);
    check("R7 config bits written", s, 8'h8C);
    wpN = 1'b0;
    cmd1(8'h06);
    csStart(); xfer(8'h01, -1, r); xfer(8'h00, -1, r); csEnd();
    rdStat(s);
    check("R7 lock keeps config bits", s, 8'h8C);
    wrByte(16'h0020, 8'h5A, 1'b1);
    rdByte(16'h0020, v);
    check("R7 lock leaves memory writable", v, 8'h5A);
    wpN = 1'b1;

    doneFlag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule